// File: doc/BRIEF.md
# Packed Luma Line Fetch Unpacker

This block reads one luma-only frame out of a word-addressed frame buffer and turns it into a serial stream of luma samples. Software-side configuration (base address, byte stride, width, height, vertical subsample factor and a format code) is presented on plain input pins and captured when a start pulse arrives. The block then walks the buffer line by line and issues one 32-bit word read at a time. It unpacks each returned word into 8-bit or 10-bit samples and marks the end of every line and the end of the frame.

Only the lines picked by the subsample factor are requested. The line start address advances by the stride multiplied by that factor, so lines that are skipped cost no read traffic. Each line begins on a fresh word. Slots left over in the last word of a line are dropped.

Top module: `luma_fetch_unpack`

## Requirements
- R1: After reset, `busy`, `rd_valid`, `pix_valid`, `pix_eol` and `pix_eof` are all low, and while `busy` is low no read request is made.
- R2: Format code 24 is 8-bit luma with four samples per word, taken from bits 7:0, 15:8, 23:16 and then 31:24. Each sample appears on `pix_data` zero-extended to 10 bits, so bits 9:8 are 0.
- R3: Format code 25 is 10-bit luma with three samples per word, taken from bits 9:0, 19:10 and then 29:20. Bits 31:30 of the word never reach the output.
- R4: Read addresses are word aligned, and the low two bits of the base address are treated as 0. Within a line, words are requested at consecutive addresses four bytes apart. Sampled line k starts at base + k·stride·N, where the stride is a multiple of 4.
- R5: A line of width W takes ceil(W/4) words in format 24 and ceil(W/3) words in format 25. Unused slots of the final word of a line are discarded, and exactly W samples come out per line.
- R6: With subsample factor N, the lines fetched are rows 0, N, 2N, … that lie below the height. A factor of 0 behaves as 1.
- R7: `pix_eol` is high with the last sample of each fetched line. `pix_eof` is high only together with the last sample of the last fetched line. Neither flag is high without `pix_valid`.
- R8: Once `rd_valid` is raised, it and `rd_addr` hold unchanged until a cycle in which `rd_ready` is high.
- R9: `busy` goes high in the cycle after an accepted start and falls in the cycle the final sample is output. A start pulse while busy is ignored, and the frame in progress keeps its captured configuration.
- R10: A start pulse with a format code other than 24 or 25, a zero width or a zero height is ignored: `busy` stays low, and no request or sample appears.
- R11: At most one read is outstanding. No new request is made until the data word for the previous one has been returned on `rd_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; configuration captured when accepted |
| cfg_format | input | 8 | Format code (24 = 8-bit, 25 = packed 10-bit) |
| cfg_base | input | ADDR_W | Frame base byte address |
| cfg_stride | input | DIM_W | Byte distance between line starts |
| cfg_width | input | DIM_W | Samples per line |
| cfg_height | input | DIM_W | Lines in the frame |
| cfg_subsample | input | DIM_W | Vertical subsample factor N |
| busy | output | 1 | Frame in progress |
| rd_addr | output | ADDR_W | Read word byte address |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data word valid |
| rd_rdata | input | 32 | Read data word |
| pix_valid | output | 1 | Sample valid |
| pix_data | output | 10 | Luma sample |
| pix_eol | output | 1 | Last sample of a line |
| pix_eof | output | 1 | Last sample of the frame |

## Verification
A wrong slot counter shows up within one word. Samples come out in the wrong lane order, or a line's word count at `rd_addr` comes out wrong, on the very first line. A wrong row counter or line-step product shows up as a bad start address on the second fetched line, or as a missing or early `pix_eof` at the end of the frame. The sweeps vary width across every remainder modulo 3 and 4 and set the subsample factor below, equal to and above the height, so each of these faults surfaces in the first few frames.

// File: rtl/luma_fetch_pkg.sv
package luma_fetch_pkg;
  localparam int WORD_W  = 32;
  localparam int PIX_W   = 10;
  localparam int LANES8  = 4;
  localparam int LANES10 = 3;
  localparam int FMT_W   = 8;
  localparam int SLOT_W  = 2;
  localparam logic [FMT_W-1:0] FMT_Y8  = 8'd24;
  localparam logic [FMT_W-1:0] FMT_Y10 = 8'd25;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_EMIT
  } fetch_st_t;
endpackage

// File: rtl/luma_fetch_seq.sv
module luma_fetch_seq import luma_fetch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FMT_W-1:0]  cfg_format,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [DIM_W-1:0]  cfg_stride,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [DIM_W-1:0]  cfg_subsample,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic [WORD_W-1:0] rd_rdata,
  output logic              busy,
  output logic              emit,
  output logic [WORD_W-1:0] word,
  output logic              fmt8,
  output logic [SLOT_W-1:0] slot,
  output logic              emit_eol,
  output logic              emit_eof
);
  localparam int ROW_W = DIM_W + 1;

  fetch_st_t         state;
  logic              fmt8_q;
  logic [DIM_W-1:0]  width_q;
  logic [ROW_W-1:0]  height_q;
  logic [ROW_W-1:0]  n_q;
  logic [ROW_W-1:0]  row_q;
  logic [DIM_W-1:0]  col_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] line_step_q;
  logic [ADDR_W-1:0] line_addr_q;
  logic [ADDR_W-1:0] word_addr_q;
  logic [WORD_W-1:0] word_q;

  logic                 cfg_ok;
  logic [DIM_W-1:0]     n_eff;
  logic [2*DIM_W-1:0]   step_prod;
  logic [ADDR_W-1:0]    base_al;
  logic                 last_col;
  logic                 last_slot;
  logic                 last_row;
  logic [ADDR_W-1:0]    next_line;

  assign cfg_ok    = ((cfg_format == FMT_Y8) || (cfg_format == FMT_Y10)) &&
                     (cfg_width != '0) && (cfg_height != '0);
  assign n_eff     = (cfg_subsample == '0) ? DIM_W'(1) : cfg_subsample;
  assign step_prod = {{DIM_W{1'b0}}, cfg_stride} * {{DIM_W{1'b0}}, n_eff};
  assign base_al   = cfg_base & ~ADDR_W'(3);

  assign last_col  = (col_q == width_q - 1'b1);
  assign last_slot = (slot_q == (fmt8_q ? 2'd3 : 2'd2));
  assign last_row  = ((row_q + n_q) >= height_q);
  assign next_line = line_addr_q + line_step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      fmt8_q      <= 1'b0;
      width_q     <= '0;
      height_q    <= '0;
      n_q         <= '0;
      row_q       <= '0;
      col_q       <= '0;
      slot_q      <= '0;
      line_step_q <= '0;
      line_addr_q <= '0;
      word_addr_q <= '0;
      word_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && cfg_ok) begin
            fmt8_q      <= (cfg_format == FMT_Y8);
            width_q     <= cfg_width;
            height_q    <= {1'b0, cfg_height};
            n_q         <= {1'b0, n_eff};
            line_step_q <= ADDR_W'(step_prod);
            line_addr_q <= base_al;
            word_addr_q <= base_al;
            row_q       <= '0;
            col_q       <= '0;
            slot_q      <= '0;
            state       <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rvalid) begin
            word_q <= rd_rdata;
            state  <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (last_col) begin
            if (last_row) begin
              state <= ST_IDLE;
            end else begin
              row_q       <= row_q + n_q;
              col_q       <= '0;
              slot_q      <= '0;
              line_addr_q <= next_line;
              word_addr_q <= next_line;
              state       <= ST_REQ;
            end
          end else begin
            col_q <= col_q + 1'b1;
            if (last_slot) begin
              slot_q      <= '0;
              word_addr_q <= word_addr_q + ADDR_W'(4);
              state       <= ST_REQ;
            end else begin
              slot_q <= slot_q + 2'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (state == ST_REQ);
  assign rd_addr  = word_addr_q;
  assign busy     = (state != ST_IDLE);
  assign emit     = (state == ST_EMIT);
  assign word     = word_q;
  assign fmt8     = fmt8_q;
  assign slot     = slot_q;
  assign emit_eol = last_col;
  assign emit_eof = last_col && last_row;

  // Outstanding-read tracker used only by the checks below
  logic [1:0] outst_q;
  always_ff @(posedge clk) begin
    if (rst) outst_q <= '0;
    else if ((rd_valid && rd_ready) && !(rd_rvalid && outst_q != '0)) outst_q <= outst_q + 2'd1;
    else if (!(rd_valid && rd_ready) && (rd_rvalid && outst_q != '0)) outst_q <= outst_q - 2'd1;
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_single_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
    (outst_q != '0) |-> !rd_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_valid && !emit));
  assert_addr_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_addr[1:0] == 2'b00));
endmodule

// File: rtl/luma_word_unpack.sv
module luma_word_unpack import luma_fetch_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              emit,
  input  logic [WORD_W-1:0] word,
  input  logic              fmt8,
  input  logic [SLOT_W-1:0] slot,
  input  logic              eol_in,
  input  logic              eof_in,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_eol,
  output logic              pix_eof
);
  logic [PIX_W-1:0] lane8  [LANES8];
  logic [PIX_W-1:0] lane10 [LANES10];
  logic [PIX_W-1:0] sel;

  for (genvar g = 0; g < LANES8; g++) begin : g_lane8
    assign lane8[g] = {{(PIX_W-8){1'b0}}, word[8*g +: 8]};
  end
  for (genvar g = 0; g < LANES10; g++) begin : g_lane10
    assign lane10[g] = word[PIX_W*g +: PIX_W];
  end

  always_comb begin
    sel = '0;
    if (fmt8) begin
      sel = lane8[slot];
    end else begin
      case (slot)
        2'd0:    sel = lane10[0];
        2'd1:    sel = lane10[1];
        2'd2:    sel = lane10[2];
        default: sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_eol   <= 1'b0;
      pix_eof   <= 1'b0;
    end else begin
      pix_valid <= emit;
      pix_eol   <= emit && eol_in;
      pix_eof   <= emit && eof_in;
      if (emit) pix_data <= sel;
    end
  end

  assert_eof_with_eol_R7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_eof) |-> pix_eol);
  assert_flags_need_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (!pix_eol && !pix_eof));
  assert_y8_top_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (emit && fmt8) |=> (pix_data[PIX_W-1:8] == '0));
endmodule

// File: rtl/luma_fetch_unpack.sv
module luma_fetch_unpack import luma_fetch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FMT_W-1:0]  cfg_format,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [DIM_W-1:0]  cfg_stride,
  input  logic [DIM_W-1:0]  cfg_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [DIM_W-1:0]  cfg_subsample,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              rd_rvalid,
  input  logic [WORD_W-1:0] rd_rdata,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_eol,
  output logic              pix_eof
);
  logic              emit;
  logic [WORD_W-1:0] word;
  logic              fmt8;
  logic [SLOT_W-1:0] slot;
  logic              emit_eol;
  logic              emit_eof;

  luma_fetch_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_format(cfg_format), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_subsample(cfg_subsample),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .busy(busy), .emit(emit), .word(word), .fmt8(fmt8), .slot(slot),
    .emit_eol(emit_eol), .emit_eof(emit_eof)
  );

  luma_word_unpack u_unpack (
    .clk(clk), .rst(rst), .emit(emit), .word(word), .fmt8(fmt8), .slot(slot),
    .eol_in(emit_eol), .eof_in(emit_eof),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_eol(pix_eol), .pix_eof(pix_eof)
  );
endmodule

// File: tb/luma_fetch_unpack_bench.sv
`timescale 1ns/1ps
module luma_fetch_unpack_bench;
  import luma_fetch_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cfg_format = '0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_stride = '0, cfg_width = '0, cfg_height = '0, cfg_subsample = '0;
  logic        busy, rd_valid, pix_valid, pix_eol, pix_eof;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0, rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic [9:0]  pix_data;

  always #2 clk = ~clk;

  luma_fetch_unpack u_luma_fetch_unpack (
    .clk(clk), .rst(rst), .start(start), .cfg_format(cfg_format), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_subsample(cfg_subsample), .busy(busy), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_eol(pix_eol), .pix_eof(pix_eof)
  );

  int n_cmp = 0, n_bad = 0;
  logic [9:0]  e_pix [512];
  logic        e_eol [512];
  logic        e_eof [512];
  logic [31:0] e_addr [512];
  int e_np = 0, e_na = 0, got_np = 0, got_na = 0;
  bit e_fmt8 = 1'b0;

  bit resp_pend = 0, hold_pend = 0;
  logic [31:0] resp_addr = '0, hold_addr = '0;
  int out_cnt = 0;
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model and output monitors, all on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      rd_ready = 1'b0;
    end else begin
      if (pix_valid) begin
        if (got_np < e_np) begin
          chk(pix_data == e_pix[got_np], e_fmt8 ? "R2" : "R3", "sample", 32'(pix_data), 32'(e_pix[got_np]));
          chk(pix_eol == e_eol[got_np], "R7", "eol", 32'(pix_eol), 32'(e_eol[got_np]));
          chk(pix_eof == e_eof[got_np], "R7", "eof", 32'(pix_eof), 32'(e_eof[got_np]));
        end else begin
          chk(1'b0, "R5", "extra sample", got_np, e_np);
        end
        got_np++;
      end
      if (hold_pend) begin
        chk(rd_valid && rd_addr == hold_addr, "R8", "request held", rd_addr, hold_addr);
        hold_pend = 0;
      end
      if (rd_rvalid) rd_rvalid = 1'b0;
      if (resp_pend) begin
        rd_rvalid = 1'b1;
        rd_rdata  = memw(resp_addr);
        resp_pend = 0;
        out_cnt--;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_ready = lfsr[0] | lfsr[1];
      if (rd_valid) begin
        if (rd_ready) begin
          chk(out_cnt == 0, "R11", "outstanding at request", out_cnt, 0);
          if (got_na < e_na) chk(rd_addr == e_addr[got_na], "R4", "address", rd_addr, e_addr[got_na]);
          else chk(1'b0, "R5", "extra request", got_na, e_na);
          got_na++;
          out_cnt++;
          resp_pend = 1;
          resp_addr = rd_addr;
        end else begin
          hold_pend = 1;
          hold_addr = rd_addr;
        end
      end
    end
  end

  task automatic run_frame(input logic [7:0] fmt, input int w, input int h, input int sub,
                           input logic [31:0] base, input int stride, input bit disturb);
    int ppw, n, wpl, to;
    logic [31:0] b, a, wd;
    ppw = (fmt == FMT_Y8) ? 4 : 3;
    n   = (sub == 0) ? 1 : sub;
    b   = base & ~32'd3;
    wpl = (w + ppw - 1) / ppw;
    e_np = 0; e_na = 0; got_np = 0; got_na = 0;
    e_fmt8 = (fmt == FMT_Y8);
    for (int r = 0; r < h; r += n) begin
      for (int i = 0; i < wpl; i++) begin
        e_addr[e_na] = b + 32'(r * stride) + 32'(4 * i);
        e_na++;
      end
      for (int c = 0; c < w; c++) begin
        a  = b + 32'(r * stride) + 32'(4 * (c / ppw));
        wd = memw(a);
        e_pix[e_np] = e_fmt8 ? {2'b00, wd[8*(c%ppw) +: 8]} : wd[10*(c%ppw) +: 10];
        e_eol[e_np] = (c == w - 1);
        e_eof[e_np] = (c == w - 1) && (r + n >= h);
        e_np++;
      end
    end
    @(negedge clk);
    cfg_format = fmt; cfg_width = 16'(w); cfg_height = 16'(h);
    cfg_subsample = 16'(sub); cfg_base = base; cfg_stride = 16'(stride);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", 32'(busy), 1);
    if (disturb) begin
      @(negedge clk);
      cfg_format = (fmt == FMT_Y8) ? FMT_Y10 : FMT_Y8;
      cfg_width = 16'd2; cfg_height = 16'd9; cfg_subsample = 16'd1;
      cfg_base = 32'h0000_0400; cfg_stride = 16'd64;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    to = 0;
    while (busy && to < 5000) begin
      @(negedge clk);
      to++;
    end
    chk(to < 5000, "R9", "busy falls", to, 0);
    repeat (3) @(negedge clk);
    chk(got_np == e_np, "R6", "sample count", got_np, e_np);
    chk(got_na == e_na, "R5", "word count", got_na, e_na);
  endtask

  task automatic run_ignored(input logic [7:0] fmt, input int w, input int h);
    e_np = 0; e_na = 0; got_np = 0; got_na = 0;
    @(negedge clk);
    cfg_format = fmt; cfg_width = 16'(w); cfg_height = 16'(h);
    cfg_subsample = 16'd1; cfg_base = 32'h100; cfg_stride = 16'd16;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after bad start", 32'(busy), 0);
    chk(got_na == 0 && got_np == 0, "R10", "activity after bad start", got_na + got_np, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int widths [8] = '{1, 2, 3, 4, 5, 6, 7, 13};
    int subs   [5] = '{0, 1, 2, 3, 7};
    int heights[2] = '{1, 5};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(!busy && !rd_valid && !pix_valid && !pix_eol && !pix_eof, "R1", "reset outputs",
        {27'd0, busy, rd_valid, pix_valid, pix_eol, pix_eof}, 0);
    for (int f = 0; f < 2; f++) begin
      for (int wi = 0; wi < 8; wi++) begin
        for (int si = 0; si < 5; si++) begin
          for (int hi = 0; hi < 2; hi++) begin
            int w, ppw, stride;
            w = widths[wi];
            ppw = (f == 0) ? 4 : 3;
            stride = 4 * ((w + ppw - 1) / ppw) + 4 * si;
            run_frame((f == 0) ? FMT_Y8 : FMT_Y10, w, heights[hi], subs[si],
                      32'h0010_0000 + 32'(64 * wi) + 32'(si % 4), stride, (w == 5));
          end
        end
      end
    end
    run_frame(FMT_Y10, 9, 9, 4, 32'h0002_0003, 20, 1'b0);
    run_ignored(8'd7, 4, 4);
    run_ignored(FMT_Y8, 0, 4);
    run_ignored(FMT_Y10, 4, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule